// File: doc/BRIEF.md
# Transparent Receive Sync Hunter

This block sits between the byte stream of one transparent-mode serial receive channel and the receive buffer writer. It decides which received byte is the first one delivered downstream. A 2-bit mode selects the rule. In free-running mode every byte is passed. In slot mode delivery starts at the byte tagged as the channel's first slot. The two pattern modes hunt for an 8-bit or a 16-bit marker. The pattern modes differ in which marker bytes reach the buffer: the 8-bit marker is dropped, while the 16-bit marker loses its first byte and keeps its second.

Once aligned, the block stays in data mode until reset or a re-hunt pulse. When the timestamp option is on, each buffer-start pulse from downstream causes a 4-byte snapshot of a free-running cycle counter to be emitted ahead of the following data. Both sides use valid/ready handshakes, so a downstream stall holds the upstream stream in place.

Top module: `rx_sync_hunter`

## Requirements
- R1: While reset is asserted, `out_valid` and `in_sync` are low.
- R2: With `mode`=00, `in_sync` is high after the first clock edge following reset release, and every byte offered from then on is forwarded in order.
- R3: With `mode`=01, bytes offered with `slot_first` low are dropped while hunting. The first byte offered with `slot_first` high is the first byte forwarded.
- R4: With `mode`=10, the hunter compares each byte with `sync_pat[15:8]`. The matching byte is dropped, and the byte after it is the first byte forwarded.
- R5: With `mode`=11, two consecutive bytes equal to `sync_pat[15:8]` and then `sync_pat[7:0]` form a match. The first of these bytes is dropped and the second is the first byte forwarded.
- R6: With `mode`=11, a byte that breaks a partial match is itself tested again as a possible first pattern byte.
- R7: While `in_sync` is low, `out_valid` stays low and nothing is forwarded.
- R8: Once `in_sync` is high, it stays high until reset or `rehunt`, and later bytes equal to the pattern are forwarded as ordinary data.
- R9: A `rehunt` pulse makes `in_sync` low in the next cycle, and the hunt starts again.
- R10: With `ts_en` high, a `buf_start` pulse captures the 32-bit cycle counter. The counter is zero in the first cycle after reset and increases by one each clock. The captured value is emitted as four bytes, most significant first, before any further data byte.
- R11: With `ts_en` low, a `buf_start` pulse inserts nothing into the output stream.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` stays stable, `in_ready` is low, and no byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Sync rule: 00 none, 01 first slot, 10 8-bit pattern, 11 16-bit pattern |
| sync_pat | input | 16 | Sync pattern; upper byte is the one received first |
| ts_en | input | 1 | Insert a timestamp header at each buffer start |
| rehunt | input | 1 | Pulse: drop alignment and hunt again |
| buf_start | input | 1 | Pulse from downstream: a new buffer begins |
| in_valid | input | 1 | Received byte available |
| in_data | input | 8 | Received byte |
| slot_first | input | 1 | Current byte occupies the channel's first slot |
| in_ready | output | 1 | Current received byte is taken this cycle |
| out_valid | output | 1 | Byte offered to the buffer writer |
| out_data | output | 8 | Timestamp or data byte |
| out_ready | input | 1 | Buffer writer accepts the byte |
| in_sync | output | 1 | Alignment achieved; data mode |

## Verification
A hunt state that is wrong shows up in the first forwarded byte. If sync arrives early, a leading junk or marker byte appears. If it arrives late, the first real byte is missing. A broken overlap re-check misses a pattern that follows a repeated first byte, and the stream then stays silent. A header index or snapshot that is wrong corrupts the four bytes just before the next data byte. A stall-handling fault shows on the next cycle with `out_ready` low, as a changed `out_data` or a raised `in_ready`.

// File: rtl/rx_sync_hunter.sv
module rx_sync_hunter #(
  parameter int TS_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [15:0] sync_pat,
  input  logic       ts_en,
  input  logic       rehunt,
  input  logic       buf_start,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       slot_first,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic       in_sync
);
  localparam int TS_W = 8 * TS_BYTES;
  localparam int IW   = (TS_BYTES > 1) ? $clog2(TS_BYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(TS_BYTES - 1);

  logic            sync_q, prev_hit, hdr_pend;
  logic [IW-1:0]   hdr_idx;
  logic [TS_W-1:0] ts_cnt, ts_snap, ts_shift;
  logic            hunt_ready, sync_set;

  wire hi_hit  = (in_data == sync_pat[15:8]);
  wire lo_hit  = (in_data == sync_pat[7:0]);
  wire hdr_out = sync_q & hdr_pend;

  always_comb begin
    case (mode)
      2'b00: begin hunt_ready = 1'b0;                  sync_set = 1'b1; end
      2'b01: begin hunt_ready = ~slot_first;           sync_set = in_valid & slot_first; end
      2'b10: begin hunt_ready = 1'b1;                  sync_set = in_valid & hi_hit; end
      default: begin hunt_ready = ~(prev_hit & lo_hit); sync_set = in_valid & prev_hit & lo_hit; end
    endcase
  end

  assign ts_shift  = ts_snap << {hdr_idx, 3'b000};
  assign out_valid = hdr_out | (sync_q & in_valid);
  assign out_data  = hdr_out ? ts_shift[TS_W-1 -: 8] : in_data;
  assign in_ready  = sync_q ? (~hdr_pend & out_ready) : hunt_ready;
  assign in_sync   = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_cnt <= '0;
    end else begin
      ts_cnt <= ts_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 1'b0;
      prev_hit <= 1'b0;
    end else if (rehunt) begin
      sync_q   <= 1'b0;
      prev_hit <= 1'b0;
    end else if (!sync_q) begin
      if (sync_set) begin
        sync_q   <= 1'b1;
        prev_hit <= 1'b0;
      end else if (mode == 2'b11 && in_valid) begin
        prev_hit <= hi_hit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_pend <= 1'b0;
      hdr_idx  <= '0;
      ts_snap  <= '0;
    end else if (buf_start && ts_en) begin
      hdr_pend <= 1'b1;
      hdr_idx  <= '0;
      ts_snap  <= ts_cnt;
    end else if (rehunt) begin
      hdr_pend <= 1'b0;
    end else if (hdr_out && out_ready) begin
      hdr_idx <= hdr_idx + 1'b1;
      if (hdr_idx == LAST) hdr_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_sync_hunter_chk.sv
module rx_sync_hunter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       rehunt,
  input logic       buf_start,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_ready,
  input logic       in_sync
);
  a_r7_quiet_hunting: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |-> !out_valid);

  a_r8_sync_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && !rehunt) |=> in_sync);

  a_r9_rehunt_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rehunt |=> !in_sync);

  a_r12_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !rehunt && !buf_start) |=> (out_valid && $stable(out_data)));

  a_r12_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && !out_ready) |-> !in_ready);

  a_r4_hunt_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !in_sync && in_valid) |-> in_ready);
endmodule

bind rx_sync_hunter rx_sync_hunter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .rehunt(rehunt), .buf_start(buf_start),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_ready(out_ready), .in_sync(in_sync)
);

// File: tb/rx_sync_hunter_tb.sv
module rx_sync_hunter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [15:0] sync_pat = 16'h0000;
  logic ts_en = 1'b0, rehunt = 1'b0, buf_start = 1'b0;
  logic in_valid = 1'b0, slot_first = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, in_sync;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  logic [7:0] cap [0:63];
  int cap_n = 0;
  logic [31:0] cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_sync_hunter u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sync_pat(sync_pat), .ts_en(ts_en),
    .rehunt(rehunt), .buf_start(buf_start), .in_valid(in_valid), .in_data(in_data),
    .slot_first(slot_first), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .in_sync(in_sync)
  );

  always @(posedge clk) begin
    cyc <= rst_n ? cyc + 1 : 32'd0;
    if (rst_n && out_valid && out_ready && cap_n < 64) begin
      cap[cap_n] = out_data;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_reset(input logic [1:0] m, input logic [15:0] p);
    @(negedge clk);
    rst_n = 1'b0; mode = m; sync_pat = p; in_valid = 1'b0; slot_first = 1'b0;
    ts_en = 1'b0; rehunt = 1'b0; buf_start = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    cap_n = 0;
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [7:0] b, input logic s);
    bit ok;
    in_valid = 1'b1; in_data = b; slot_first = s;
    ok = 0;
    while (!ok) begin
      #1 ok = in_ready;
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; slot_first = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_caps(input string tag, input int n, input logic [7:0] e0,
                             input logic [7:0] e1, input logic [7:0] e2, input logic [7:0] e3);
    logic [7:0] e [0:3];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
    chk(cap_n == n, {tag, " count"}, cap_n, n);
    for (int i = 0; i < n && i < 4; i++)
      chk(cap[i] == e[i], {tag, " byte"}, cap[i], e[i]);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; mode = 2'b00; #1;
    chk(!out_valid && !in_sync, "R1 reset quiet", {out_valid, in_sync}, 0);
    @(negedge clk);
    chk(!out_valid && !in_sync, "R1 reset held", {out_valid, in_sync}, 0);
  endtask

  task automatic t_free();
    do_reset(2'b00, 16'h0000);
    @(negedge clk);
    chk(in_sync == 1'b1, "R2 in_sync after first edge", in_sync, 1);
    send(8'hA1, 0); send(8'hA2, 0); send(8'hA3, 0); idle(2);
    expect_caps("R2 free stream", 3, 8'hA1, 8'hA2, 8'hA3, 8'h00);
  endtask

  task automatic t_slot();
    do_reset(2'b01, 16'h0000);
    send(8'h11, 0); send(8'h22, 0); idle(1);
    chk(cap_n == 0 && !in_sync, "R3 R7 nothing before slot", cap_n, 0);
    send(8'h33, 1); send(8'h44, 0); idle(2);
    expect_caps("R3 slot start", 2, 8'h33, 8'h44, 8'h00, 8'h00);
  endtask

  task automatic t_pat8();
    do_reset(2'b10, 16'h7E00);
    send(8'h01, 0); send(8'h7E, 0); send(8'h55, 0); send(8'h7E, 0); send(8'h66, 0); idle(2);
    expect_caps("R4 R8 8-bit hunt", 3, 8'h55, 8'h7E, 8'h66, 8'h00);
  endtask

  task automatic t_pat16();
    do_reset(2'b11, 16'hA55A);
    send(8'h00, 0); send(8'hA5, 0); idle(1);
    chk(!in_sync && cap_n == 0, "R7 half match silent", cap_n, 0);
    send(8'h5A, 0); send(8'h11, 0); send(8'h22, 0); idle(2);
    expect_caps("R5 16-bit hunt", 3, 8'h5A, 8'h11, 8'h22, 8'h00);
  endtask

  task automatic t_overlap();
    do_reset(2'b11, 16'hABCD);
    send(8'h12, 0); send(8'hCD, 0); send(8'h34, 0); idle(1);
    chk(!in_sync && cap_n == 0, "R7 no false sync", in_sync, 0);
    send(8'hAB, 0); send(8'hAB, 0); send(8'hCD, 0); send(8'h77, 0); idle(2);
    expect_caps("R6 overlap recheck", 2, 8'hCD, 8'h77, 8'h00, 8'h00);
  endtask

  task automatic t_rehunt();
    do_reset(2'b10, 16'h7E00);
    send(8'h7E, 0); send(8'h01, 0);
    rehunt = 1'b1; @(negedge clk); rehunt = 1'b0;
    chk(!in_sync, "R9 rehunt drops sync", in_sync, 0);
    send(8'h02, 0); send(8'h7E, 0); send(8'h03, 0); idle(2);
    expect_caps("R9 rehunt stream", 2, 8'h01, 8'h03, 8'h00, 8'h00);
  endtask

  task automatic t_stamp();
    logic [31:0] ts;
    do_reset(2'b10, 16'h7E00);
    ts_en = 1'b1;
    send(8'h7E, 0); idle(3);
    ts = cyc; buf_start = 1'b1; @(negedge clk); buf_start = 1'b0;
    send(8'h09, 0); idle(2);
    chk(cap_n == 5, "R10 header count", cap_n, 5);
    chk({cap[0], cap[1], cap[2], cap[3]} == ts, "R10 header value msb first",
        {cap[0], cap[1], cap[2], cap[3]}, ts);
    chk(cap[4] == 8'h09, "R10 data after header", cap[4], 8'h09);
  endtask

  task automatic t_nostamp();
    do_reset(2'b10, 16'h7E00);
    send(8'h7E, 0);
    buf_start = 1'b1; @(negedge clk); buf_start = 1'b0;
    send(8'h42, 0); idle(2);
    expect_caps("R11 no header", 1, 8'h42, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_stall();
    do_reset(2'b00, 16'h0000);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'hC3;
    @(negedge clk);
    chk(out_valid && !in_ready && out_data == 8'hC3, "R12 stall offer", out_data, 8'hC3);
    idle(2);
    chk(out_valid && !in_ready && out_data == 8'hC3 && cap_n == 0, "R12 stall held", cap_n, 0);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    idle(2);
    expect_caps("R12 released once", 1, 8'hC3, 8'h00, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    t_reset();
    t_free();
    t_slot();
    t_pat8();
    t_pat16();
    t_overlap();
    t_rehunt();
    t_stamp();
    t_nostamp();
    t_stall();
    done = 1;
    summary();
  end
endmodule